// File: doc/BRIEF.md
# Two-Stream Color Plane Merger

This block joins two video streams that run in step into a single output stream. Each beat on an input carries `PIP` pixels side by side. Each pixel holds up to four color planes of `BITS` bits. Two four-bit masks, fixed when the block is built, select which planes of each input go into the output pixel. The selected planes are packed together with no gaps: the planes taken from input 0 come first, then the planes taken from input 1.

Each stream uses a valid/ready/last handshake in the AXI4-Stream style, plus a one-bit packet-type sideband. The sideband is 0 for a video beat and 1 for a metapacket beat. A video beat moves only when both inputs offer video at the same time, and then both inputs are consumed together. A metapacket on either input is handled alone while the other input waits. A build option decides whether metapackets from input 1 are forwarded to the output or quietly consumed. The block holds no storage for data, and the output is a combinational view of the inputs.

The sum of the two mask populations must equal `OUT_PLANES`, and no mask may select a plane above its input's plane count. Both rules are checked when the block is elaborated.

Top module: `plane_merge2`

## Requirements
- R1: On a video beat, output pixel p sits at bits [p*OUT_PLANES*BITS +: OUT_PLANES*BITS], and plane k of that pixel sits at offset k*BITS inside it. The kept planes of input 0, in ascending index order, fill the lowest plane positions. The kept planes of input 1 follow, also in ascending order. With the default masks (input 0 keeps planes 0 and 2, input 1 keeps plane 1), the output pixel is {in1 plane1, in0 plane2, in0 plane0}, with in0 plane0 in the least significant position.
- R2: Input planes whose keep bit is clear have no effect on the output data.
- R3: When no metapacket is in progress and neither input offers a metapacket, a video beat is offered (outValid=1) only if both inputs are valid with the sideband at 0. In that case both ready outputs equal outReady. Otherwise both ready outputs are 0.
- R4: A metapacket beat from input 0 is forwarded with outMeta=1. Its data is the low output-width bits of the input data, zero-extended if the input is narrower. outLast copies the input 0 last flag. in0Ready equals outReady, and in1Ready is 0.
- R5: If both inputs start a metapacket in the same cycle, input 0 is served first.
- R6: Once a metapacket has started on one input, that input alone owns the output until its beat with last=1 is accepted. The other input's ready stays 0 during this time, even if the owning input drops valid.
- R7: With KEEP_META1=1, metapackets from input 1 are forwarded in the same way as in R4, with the roles of the inputs swapped.
- R8: With KEEP_META1=0, metapacket beats from input 1 are consumed with in1Ready=1 and outValid=0.
- R9: On a video beat, outLast equals the last flag of input 0.
- R10: While outReady is 0, no forwarded beat is consumed: in0Ready is 0, and in1Ready is 0 except while input 1 metapackets are being dropped.
- R11: While rstN is low, outValid, in0Ready and in1Ready are all 0, whatever the inputs do.

Ports are listed in the order of the port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream clock |
| rstN | input | 1 | Active-low synchronous reset |
| in0Data | input | PIP*IN0_PLANES*BITS | Input 0 beat payload |
| in0Valid | input | 1 | Input 0 beat offered |
| in0Meta | input | 1 | Input 0 packet type (1 = metapacket) |
| in0Last | input | 1 | Input 0 end of line or packet |
| in0Ready | output | 1 | Input 0 beat accepted |
| in1Data | input | PIP*IN1_PLANES*BITS | Input 1 beat payload |
| in1Valid | input | 1 | Input 1 beat offered |
| in1Meta | input | 1 | Input 1 packet type (1 = metapacket) |
| in1Last | input | 1 | Input 1 end of line or packet |
| in1Ready | output | 1 | Input 1 beat accepted |
| outData | output | PIP*OUT_PLANES*BITS | Output beat payload |
| outValid | output | 1 | Output beat offered |
| outMeta | output | 1 | Output packet type (1 = metapacket) |
| outLast | output | 1 | Output end of line or packet |
| outReady | input | 1 | Downstream accepts beat |

## Verification
The assertions check the handshake rules on every cycle. They cover the lockstep ready pairing of video beats, the blocking of the waiting input while a metapacket owns the output, the rule that every output transfer is backed by an input transfer, backpressure, and the drop rule for input 1 metapackets. The bench scenarios are needed to show the rest. That includes the plane packing order and its independence from unkept planes, input 0 winning a simultaneous metapacket start, ownership lasting across a gap in valid, and the different outcome for the same input 1 metapacket in the forwarding build and the dropping build.

// File: rtl/plane_merge_pkg.sv
package plane_merge_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOCK0 = 2'd1,
    ST_LOCK1 = 2'd2
  } mergeState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic selMeta0;
    logic selMeta1;
    logic selVideo;
  } mergeSel_t;

  // number of set mask bits strictly below plane index idx
  function automatic int keptBelow(input logic [3:0] mask, input int idx);
    int n;
    n = 0;
    for (int i = 0; i < 4; i++) begin
      if (i < idx && mask[i]) n++;
    end
    return n;
  endfunction

  function automatic int keptCount(input logic [3:0] mask);
    return keptBelow(mask, 4);
  endfunction

endpackage

// File: rtl/plane_merge_ctrl.sv
module plane_merge_ctrl
  import plane_merge_pkg::*;
#(
  parameter bit KEEP_META1 = 1'b1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      in0Valid,
  input  logic      in0Meta,
  input  logic      in0Last,
  output logic      in0Ready,
  input  logic      in1Valid,
  input  logic      in1Meta,
  input  logic      in1Last,
  output logic      in1Ready,
  input  logic      outReady,
  output logic      outValid,
  output mergeSel_t sel
);

  mergeState_e state, nextState;
  logic useMeta0, useMeta1, useVideo;

  always_comb begin
    useMeta0 = 1'b0;
    useMeta1 = 1'b0;
    useVideo = 1'b0;
    if (rstN) begin
      unique case (state)
        ST_LOCK0: useMeta0 = 1'b1;
        ST_LOCK1: useMeta1 = 1'b1;
        default: begin
          if (in0Valid && in0Meta)            useMeta0 = 1'b1;
          else if (in1Valid && in1Meta)       useMeta1 = 1'b1;
          else if (in0Valid && in1Valid)      useVideo = 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    sel          = '0;
    outValid     = 1'b0;
    in0Ready     = 1'b0;
    in1Ready     = 1'b0;
    nextState    = state;
    if (useMeta0) begin
      sel.selMeta0 = 1'b1;
      outValid     = in0Valid;
      in0Ready     = outReady;
      if (in0Valid && outReady) nextState = in0Last ? ST_IDLE : ST_LOCK0;
    end else if (useMeta1) begin
      if (KEEP_META1) begin
        sel.selMeta1 = 1'b1;
        outValid     = in1Valid;
        in1Ready     = outReady;
      end else begin
        in1Ready     = 1'b1;
      end
      if (in1Valid && in1Ready) nextState = in1Last ? ST_IDLE : ST_LOCK1;
    end else if (useVideo) begin
      sel.selVideo = 1'b1;
      outValid     = 1'b1;
      in0Ready     = outReady;
      in1Ready     = outReady;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // a video beat taken from input 0 outside a metapacket pulls input 1 along
  assert_lockstep_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && in0Valid && in0Ready && !in0Meta)
      |-> (in1Valid && in1Ready && !in1Meta));

  assert_hold_in1_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOCK0) |-> !in1Ready);

  assert_hold_in0_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOCK1) |-> !in0Ready);

  assert_backpressure_R10: assert property (@(posedge clk) disable iff (!rstN)
    !outReady |-> !in0Ready);

  assert_out_backed_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady) |-> ((in0Valid && in0Ready) || (in1Valid && in1Ready)));

  if (!KEEP_META1) begin : gDropChk
    assert_drop_meta1_R8: assert property (@(posedge clk) disable iff (!rstN)
      (in1Valid && in1Ready && in1Meta) |-> !outValid);
  end

endmodule

// File: rtl/plane_merge_dp.sv
module plane_merge_dp
  import plane_merge_pkg::*;
#(
  parameter int         BITS       = 8,
  parameter int         PIP        = 2,
  parameter int         IN0_PLANES = 3,
  parameter int         IN1_PLANES = 3,
  parameter int         OUT_PLANES = 3,
  parameter logic [3:0] KEEP0      = 4'b0101,
  parameter logic [3:0] KEEP1      = 4'b0010,
  localparam int        IN0_W      = PIP * IN0_PLANES * BITS,
  localparam int        IN1_W      = PIP * IN1_PLANES * BITS,
  localparam int        OUT_W      = PIP * OUT_PLANES * BITS
) (
  input  logic             clk,
  input  logic             rstN,
  input  mergeSel_t        sel,
  input  logic [IN0_W-1:0] in0Data,
  input  logic             in0Last,
  input  logic [IN1_W-1:0] in1Data,
  input  logic             in1Last,
  output logic [OUT_W-1:0] outData,
  output logic             outLast,
  output logic             outMeta
);

  localparam int KEPT0 = keptCount(KEEP0);

  logic [OUT_W-1:0] videoData;
  logic [OUT_W-1:0] meta0Data;
  logic [OUT_W-1:0] meta1Data;

  for (genvar p = 0; p < PIP; p++) begin : gPix
    for (genvar c = 0; c < 4; c++) begin : gPlane
      if (KEEP0[c]) begin : gTake0
        localparam int DST = p * OUT_PLANES + keptBelow(KEEP0, c);
        assign videoData[DST*BITS +: BITS] = in0Data[(p*IN0_PLANES + c)*BITS +: BITS];
      end
      if (KEEP1[c]) begin : gTake1
        localparam int DST = p * OUT_PLANES + KEPT0 + keptBelow(KEEP1, c);
        assign videoData[DST*BITS +: BITS] = in1Data[(p*IN1_PLANES + c)*BITS +: BITS];
      end
    end
  end

  if (IN0_W >= OUT_W) begin : gFit0
    assign meta0Data = in0Data[OUT_W-1:0];
  end else begin : gPad0
    assign meta0Data = {{(OUT_W-IN0_W){1'b0}}, in0Data};
  end

  if (IN1_W >= OUT_W) begin : gFit1
    assign meta1Data = in1Data[OUT_W-1:0];
  end else begin : gPad1
    assign meta1Data = {{(OUT_W-IN1_W){1'b0}}, in1Data};
  end

  always_comb begin
    outData = '0;
    outLast = 1'b0;
    outMeta = 1'b0;
    if (sel.selVideo) begin
      outData = videoData;
      outLast = in0Last;
    end else if (sel.selMeta1) begin
      outData = meta1Data;
      outLast = in1Last;
      outMeta = 1'b1;
    end else if (sel.selMeta0) begin
      outData = meta0Data;
      outLast = in0Last;
      outMeta = 1'b1;
    end
  end

  assert_sel_onehot_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sel));

endmodule

// File: rtl/plane_merge2.sv
module plane_merge2
  import plane_merge_pkg::*;
#(
  parameter int         BITS       = 8,
  parameter int         PIP        = 2,
  parameter int         IN0_PLANES = 3,
  parameter int         IN1_PLANES = 3,
  parameter int         OUT_PLANES = 3,
  parameter logic [3:0] KEEP0      = 4'b0101,
  parameter logic [3:0] KEEP1      = 4'b0010,
  parameter bit         KEEP_META1 = 1'b1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [PIP*IN0_PLANES*BITS-1:0]   in0Data,
  input  logic                             in0Valid,
  input  logic                             in0Meta,
  input  logic                             in0Last,
  output logic                             in0Ready,
  input  logic [PIP*IN1_PLANES*BITS-1:0]   in1Data,
  input  logic                             in1Valid,
  input  logic                             in1Meta,
  input  logic                             in1Last,
  output logic                             in1Ready,
  output logic [PIP*OUT_PLANES*BITS-1:0]   outData,
  output logic                             outValid,
  output logic                             outMeta,
  output logic                             outLast,
  input  logic                             outReady
);

  if (keptCount(KEEP0) + keptCount(KEEP1) != OUT_PLANES) begin : gBadCount
    $error("kept plane total does not match OUT_PLANES");
  end
  if ((KEEP0 >> IN0_PLANES) != 4'd0 || (KEEP1 >> IN1_PLANES) != 4'd0) begin : gBadMask
    $error("keep mask selects a plane the input does not carry");
  end

  mergeSel_t sel;

  plane_merge_ctrl #(
    .KEEP_META1(KEEP_META1)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .in0Valid (in0Valid),
    .in0Meta  (in0Meta),
    .in0Last  (in0Last),
    .in0Ready (in0Ready),
    .in1Valid (in1Valid),
    .in1Meta  (in1Meta),
    .in1Last  (in1Last),
    .in1Ready (in1Ready),
    .outReady (outReady),
    .outValid (outValid),
    .sel      (sel)
  );

  plane_merge_dp #(
    .BITS       (BITS),
    .PIP        (PIP),
    .IN0_PLANES (IN0_PLANES),
    .IN1_PLANES (IN1_PLANES),
    .OUT_PLANES (OUT_PLANES),
    .KEEP0      (KEEP0),
    .KEEP1      (KEEP1)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .sel     (sel),
    .in0Data (in0Data),
    .in0Last (in0Last),
    .in1Data (in1Data),
    .in1Last (in1Last),
    .outData (outData),
    .outLast (outLast),
    .outMeta (outMeta)
  );

endmodule

// File: tb/plane_merge2_tb.sv
module plane_merge2_tb;

  localparam int W = 48;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] d0 = '0, d1 = '0;
  logic v0 = 0, m0 = 0, l0 = 0, v1 = 0, m1 = 0, l1 = 0, oRdy = 0;

  logic [W-1:0] fData, xData;
  logic fValid, fMeta, fLast, fR0, fR1;
  logic xValid, xMeta, xLast, xR0, xR1;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  plane_merge2 u_dut (
    .clk(clk), .rstN(rstN),
    .in0Data(d0), .in0Valid(v0), .in0Meta(m0), .in0Last(l0), .in0Ready(fR0),
    .in1Data(d1), .in1Valid(v1), .in1Meta(m1), .in1Last(l1), .in1Ready(fR1),
    .outData(fData), .outValid(fValid), .outMeta(fMeta), .outLast(fLast),
    .outReady(oRdy)
  );

  plane_merge2 #(.KEEP_META1(1'b0)) u_dutDrop (
    .clk(clk), .rstN(rstN),
    .in0Data(d0), .in0Valid(v0), .in0Meta(m0), .in0Last(l0), .in0Ready(xR0),
    .in1Data(d1), .in1Valid(v1), .in1Meta(m1), .in1Last(l1), .in1Ready(xR1),
    .outData(xData), .outValid(xValid), .outMeta(xMeta), .outLast(xLast),
    .outReady(oRdy)
  );

  // packing per R1 with the default masks
  function automatic logic [W-1:0] expMerge(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r;
    for (int p = 0; p < 2; p++) begin
      r[(p*3+0)*8 +: 8] = a[(p*3+0)*8 +: 8];
      r[(p*3+1)*8 +: 8] = a[(p*3+2)*8 +: 8];
      r[(p*3+2)*8 +: 8] = b[(p*3+1)*8 +: 8];
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic a0, input logic am, input logic al, input logic [W-1:0] ad,
                       input logic b0, input logic bm, input logic bl, input logic [W-1:0] bd,
                       input logic r);
    @(negedge clk);
    v0 = a0; m0 = am; l0 = al; d0 = ad;
    v1 = b0; m1 = bm; l1 = bl; d1 = bd;
    oRdy = r;
    #1;
  endtask

  task automatic summary;
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired, all requirements actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a, b, c;
    void'($urandom(32'd4242));

    // R11: reset holds everything quiet even with valid inputs
    drive(1, 0, 0, 48'h1, 1, 0, 0, 48'h2, 1);
    chk("R11 outValid in reset", fValid, 0);
    chk("R11 in0Ready in reset", fR0, 0);
    chk("R11 in1Ready in reset", fR1, 0);
    chk("R11 drop build in1Ready in reset", xR1, 0);
    drive(0, 0, 0, '0, 0, 0, 0, '0, 1);
    rstN = 1'b1;

    // R5/R4: both start metapackets, input 0 wins
    a = 48'hA1A2A3A4A5A6; b = 48'hB1B2B3B4B5B6;
    drive(1, 1, 0, a, 1, 1, 0, b, 1);
    chk("R5 outValid", fValid, 1);
    chk("R4 outMeta", fMeta, 1);
    chk("R4 outData", fData, a);
    chk("R4 outLast", fLast, 0);
    chk("R4 in0Ready", fR0, 1);
    chk("R5 in1Ready held", fR1, 0);
    chk("R5 drop build in1Ready held", xR1, 0);

    // R6: gap in input 0 valid, input 1 still held
    drive(0, 1, 0, a, 1, 1, 0, b, 1);
    chk("R6 outValid during gap", fValid, 0);
    chk("R6 in1Ready during gap", fR1, 0);
    chk("R6 drop build in1Ready during gap", xR1, 0);

    // R10: closing beat under backpressure
    c = 48'hC0C1C2C3C4C5;
    drive(1, 1, 1, c, 1, 1, 0, b, 0);
    chk("R10 outValid", fValid, 1);
    chk("R10 in0Ready", fR0, 0);
    chk("R4 outLast closing", fLast, 1);

    // R4: closing beat accepted
    drive(1, 1, 1, c, 1, 1, 0, b, 1);
    chk("R4 closing in0Ready", fR0, 1);
    chk("R6 in1Ready on closing", fR1, 0);

    // R7 / R8: input 1 metapacket, input 0 offers video
    a = 48'h111111111111; b = 48'hD0D1D2D3D4D5;
    drive(1, 0, 0, a, 1, 1, 1, b, 1);
    chk("R7 outValid", fValid, 1);
    chk("R7 outMeta", fMeta, 1);
    chk("R7 outData", fData, b);
    chk("R7 outLast", fLast, 1);
    chk("R7 in1Ready", fR1, 1);
    chk("R7 in0Ready held", fR0, 0);
    chk("R8 drop outValid", xValid, 0);
    chk("R8 drop in1Ready", xR1, 1);
    chk("R8 drop in0Ready", xR0, 0);

    // R3: only one input offers video
    drive(1, 0, 0, a, 0, 0, 0, b, 1);
    chk("R3 single valid outValid", fValid, 0);
    chk("R3 single valid in0Ready", fR0, 0);
    drive(0, 0, 0, a, 1, 0, 0, b, 1);
    chk("R3 single valid in1Ready", fR1, 0);

    // R2: unkept planes changed, output unchanged
    a = 48'h0102030405A6; b = 48'h0708090A0B0C;
    drive(1, 0, 0, a, 1, 0, 0, b, 1);
    c = fData;
    drive(1, 0, 0, a ^ 48'h00FF0000FF00, 1, 0, 0, b ^ 48'hFF00FFFF00FF, 1);
    chk("R2 unkept planes ignored", fData, c);
    chk("R1 directed packing", fData, expMerge(a, b));

    // R1/R3/R9/R10 random video beats
    for (int i = 0; i < 400; i++) begin
      logic rv0, rv1, rl, rr;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      rv0 = 1'($urandom); rv1 = 1'($urandom);
      rl  = 1'($urandom); rr  = 1'($urandom);
      drive(rv0, 0, rl, a, rv1, 0, 1'($urandom), b, rr);
      chk("R3 outValid", fValid, rv0 & rv1);
      chk("R3 in0Ready", fR0, rv0 & rv1 & rr);
      chk("R3 in1Ready", fR1, rv0 & rv1 & rr);
      chk("R3 drop build in1Ready", xR1, rv0 & rv1 & rr);
      if (!rr) chk("R10 no take under backpressure", fR0 | fR1, 0);
      if (rv0 & rv1) begin
        chk("R1 packing", fData, expMerge(a, b));
        chk("R1 packing drop build", xData, expMerge(a, b));
        chk("R9 outLast", fLast, rl);
        chk("R3 outMeta video", fMeta, 0);
      end
    end

    drive(0, 0, 0, '0, 0, 0, 0, '0, 0);
    finished = 1;
    summary();
    $finish;
  end

endmodule